// File: doc/BRIEF.md
# Cycle-Stealing DMA Arbiter with Parity Tracking

This block is the DMA unit that sits beside a small processor. It keeps a flop that alternates between odd and even on every CPU cycle. It runs two kinds of transfer that take the bus away from the processor. The first is a 256-byte copy into sprite memory, started when the CPU writes a page number to a trigger address. The second is a single-byte sample fetch, requested from time to time by an audio channel. During a transfer the block holds the processor through a ready output and drives the DMA bus itself.

The length of a sample-fetch stall depends on the parity of the cycle in which the halt is taken. It also depends on whether the processor was in a run of write cycles when the request arrived. While the processor is held, its pending read is issued again on the bus. Those repeated reads act as extra clocks for a read-clocked peripheral, such as a serial controller port. The block flags each repeated read on a pulse output. A region option suppresses that pulse entirely.

Software can avoid the repeated reads by keeping its peripheral reads on even cycles. The block guarantees that the first cycle after a sprite copy is even, which gives that alignment a known starting point.

Top module: `dma_steal_arb`

## Requirements
- R1: `parity_o` is 1 (odd) while reset is asserted and inverts on every clock edge after reset.
- R2: A sample fetch whose halt cycle is odd holds `rdy_o` low for exactly 4 cycles, starting with the halt cycle. On the last of those cycles the block puts the latched fetch address on `dma_addr_o` with `dma_rd_o` high. In the next cycle it pulses `fetch_vld_o`, with `fetch_data_o` equal to the byte read.
- R3: A halt is never taken in a CPU write cycle (`cpu_rd_i` = 0). A pending fetch waits through any run of writes and halts on the first read cycle after it.
- R4: A sample fetch whose halt cycle is even holds `rdy_o` low for exactly 3 cycles and produces no `dup_rd_o` pulse.
- R5: In a 4-cycle fetch stall, `dup_rd_o` is high on the second and third stall cycles and low otherwise. It is never high while `rdy_o` is high.
- R6: While `region_fix_i` is 1, `dup_rd_o` stays 0 and stall lengths are unchanged.
- R7: A request pulse on `fetch_req_i` in cycle c is pending from cycle c+1. It first becomes eligible on an odd cycle at or after c+1, so a request raised on an odd cycle cannot halt in the even cycle that follows.
- R8: A CPU write to `SPR_REG_ADDR` starts a sprite copy that stalls the CPU from the next cycle. The copy makes 256 reads of {page, index}, with index counting up from 0, each on an even cycle. Each read is followed on the next odd cycle by a write of that byte to `SPR_DATA_ADDR`. The stall lasts 514 cycles when the trigger write is on an odd cycle and 513 cycles when it is on an even cycle.
- R9: The first cycle after a sprite copy is even (`parity_o` = 0).
- R10: A sample fetch that becomes eligible during a sprite copy takes the place of one sprite read slot. This lengthens the copy by exactly 2 cycles and leaves the 256 copied bytes intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU cycle clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU bus address of the current cycle |
| cpu_rd_i | input | 1 | 1 = CPU read cycle, 0 = CPU write cycle |
| cpu_wdata_i | input | 8 | CPU write data (the page number on a trigger write) |
| fetch_req_i | input | 1 | Sample-fetch request pulse |
| fetch_addr_i | input | 16 | Sample address, captured with the request |
| region_fix_i | input | 1 | Suppresses repeated-read pulses |
| dma_rdata_i | input | 8 | Read data returned on the DMA bus |
| rdy_o | output | 1 | CPU may proceed (0 = stalled) |
| dma_addr_o | output | 16 | DMA bus address |
| dma_rd_o | output | 1 | DMA read strobe |
| dma_we_o | output | 1 | DMA write strobe into sprite memory |
| dma_wdata_o | output | 8 | DMA write data |
| dup_rd_o | output | 1 | The held CPU read is being issued again in this cycle |
| parity_o | output | 1 | Cycle parity, 1 = odd |
| fetch_vld_o | output | 1 | Fetched sample byte is valid |
| fetch_data_o | output | 8 | Fetched sample byte |

## Verification
The hardest case to reach from the ports is a fetch halt that has been pushed onto a cycle of the other parity by CPU writes, since that is the only way to get the 3-cycle stall. The directed tests line up the request with a known parity by first running idle reads until `parity_o` reads the wanted value. They then place exactly one or two write cycles before the next read. A fetch request raised deep inside a sprite copy covers the slot-sharing case. Long random streams of mixed reads and writes, with well-spaced requests, then check each stall against the length and repeated-read count expected for its halt parity.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;
  localparam int unsigned AW          = 16;
  localparam int unsigned DW          = 8;
  localparam int unsigned SPR_N       = 256;
  localparam int unsigned SPR_IW      = $clog2(SPR_N);
  localparam int unsigned PAGE_W      = AW - SPR_IW;
  localparam int unsigned STL_ODD_LEN = 4;
  localparam int unsigned STL_EVN_LEN = 3;
  localparam int unsigned STL_CW      = $clog2(STL_ODD_LEN + 1);

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] data_t;
endpackage

// File: rtl/dma_par_ctr.sv
module dma_par_ctr (
  input  logic clk_i,
  input  logic rst_ni,
  output logic odd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) odd_o <= 1'b1;
    else         odd_o <= ~odd_o;
  end
endmodule

// File: rtl/dma_fetch_ctl.sv
module dma_fetch_ctl
  import dma_steal_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  addr_t addr_i,
  input  logic  cpu_rd_i,
  input  logic  par_odd_i,
  input  logic  spr_busy_i,
  input  logic  spr_slot_i,
  input  logic  fix_i,
  input  data_t rdata_i,
  output logic  stall_o,
  output logic  get_o,
  output logic  take_o,
  output logic  dup_o,
  output addr_t addr_o,
  output logic  vld_o,
  output data_t data_o
);
  logic              pend_q, arm_q, odd_q;
  logic [STL_CW-1:0] cnt_q;
  addr_t             addr_q;
  logic              armed, halt;

  // eligible only once an odd cycle has been seen while pending
  assign armed   = pend_q && (arm_q || par_odd_i);
  assign halt    = armed && cpu_rd_i && !spr_busy_i && (cnt_q == '0);
  assign take_o  = armed && spr_slot_i;
  assign get_o   = take_o || (cnt_q == STL_CW'(1));
  assign stall_o = halt || (cnt_q != '0);
  assign dup_o   = (cnt_q > STL_CW'(1)) && odd_q && !fix_i;
  assign addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
      odd_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      if (halt || take_o) begin
        pend_q <= 1'b0;
        arm_q  <= 1'b0;
      end else if (req_i && !pend_q) begin
        pend_q <= 1'b1;
        arm_q  <= 1'b0;
        addr_q <= addr_i;
      end else if (pend_q && par_odd_i) begin
        arm_q  <= 1'b1;
      end
      if (halt) begin
        cnt_q <= par_odd_i ? STL_CW'(STL_ODD_LEN - 1) : STL_CW'(STL_EVN_LEN - 1);
        odd_q <= par_odd_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - STL_CW'(1);
      end
      vld_o <= get_o;
      if (get_o) data_o <= rdata_i;
    end
  end
endmodule

// File: rtl/dma_spr_ctl.sv
module dma_spr_ctl
  import dma_steal_pkg::*;
#(
  parameter addr_t DATA_ADDR = 16'h7F01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              par_odd_i,
  input  logic              take_i,
  input  data_t             rdata_i,
  output logic              busy_o,
  output logic              slot_o,
  output logic              rd_o,
  output logic              we_o,
  output addr_t             addr_o,
  output data_t             wdata_o
);
  logic              first_q, have_q;
  logic [PAGE_W-1:0] page_q;
  logic [SPR_IW-1:0] idx_q;
  data_t             byte_q;

  // reads on even cycles, writes on odd; first busy cycle is the halt
  assign slot_o  = busy_o && !first_q && !par_odd_i && !have_q;
  assign rd_o    = slot_o && !take_i;
  assign we_o    = busy_o && !first_q && par_odd_i && have_q;
  assign addr_o  = rd_o ? {page_q, idx_q} : DATA_ADDR;
  assign wdata_o = byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      first_q <= 1'b0;
      have_q  <= 1'b0;
      page_q  <= '0;
      idx_q   <= '0;
      byte_q  <= '0;
    end else if (start_i) begin
      busy_o  <= 1'b1;
      first_q <= 1'b1;
      have_q  <= 1'b0;
      page_q  <= page_i;
      idx_q   <= '0;
    end else if (busy_o) begin
      first_q <= 1'b0;
      if (rd_o) begin
        have_q <= 1'b1;
        byte_q <= rdata_i;
      end
      if (we_o) begin
        have_q <= 1'b0;
        idx_q  <= idx_q + SPR_IW'(1);
        if (idx_q == SPR_IW'(SPR_N - 1)) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_steal_arb.sv
module dma_steal_arb
  import dma_steal_pkg::*;
#(
  parameter addr_t SPR_REG_ADDR  = 16'h7F00,
  parameter addr_t SPR_DATA_ADDR = 16'h7F01
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [dma_steal_pkg::AW-1:0]   cpu_addr_i,
  input  logic                           cpu_rd_i,
  input  logic [dma_steal_pkg::DW-1:0]   cpu_wdata_i,
  input  logic                           fetch_req_i,
  input  logic [dma_steal_pkg::AW-1:0]   fetch_addr_i,
  input  logic                           region_fix_i,
  input  logic [dma_steal_pkg::DW-1:0]   dma_rdata_i,
  output logic                           rdy_o,
  output logic [dma_steal_pkg::AW-1:0]   dma_addr_o,
  output logic                           dma_rd_o,
  output logic                           dma_we_o,
  output logic [dma_steal_pkg::DW-1:0]   dma_wdata_o,
  output logic                           dup_rd_o,
  output logic                           parity_o,
  output logic                           fetch_vld_o,
  output logic [dma_steal_pkg::DW-1:0]   fetch_data_o
);
  logic  par_odd;
  logic  spr_start, spr_busy, spr_slot, spr_rd, spr_we;
  logic  f_stall, f_get, f_take;
  addr_t spr_addr, f_addr;

  assign spr_start = rdy_o && !cpu_rd_i && (cpu_addr_i == SPR_REG_ADDR);

  dma_par_ctr u_par (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .odd_o (par_odd)
  );

  dma_spr_ctl #(.DATA_ADDR(SPR_DATA_ADDR)) u_spr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (spr_start),
    .page_i   (cpu_wdata_i[PAGE_W-1:0]),
    .par_odd_i(par_odd),
    .take_i   (f_take),
    .rdata_i  (dma_rdata_i),
    .busy_o   (spr_busy),
    .slot_o   (spr_slot),
    .rd_o     (spr_rd),
    .we_o     (spr_we),
    .addr_o   (spr_addr),
    .wdata_o  (dma_wdata_o)
  );

  dma_fetch_ctl u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (fetch_req_i),
    .addr_i    (fetch_addr_i),
    .cpu_rd_i  (cpu_rd_i),
    .par_odd_i (par_odd),
    .spr_busy_i(spr_busy),
    .spr_slot_i(spr_slot),
    .fix_i     (region_fix_i),
    .rdata_i   (dma_rdata_i),
    .stall_o   (f_stall),
    .get_o     (f_get),
    .take_o    (f_take),
    .dup_o     (dup_rd_o),
    .addr_o    (f_addr),
    .vld_o     (fetch_vld_o),
    .data_o    (fetch_data_o)
  );

  assign rdy_o      = !(spr_busy || f_stall);
  assign dma_rd_o   = spr_rd || f_get;
  assign dma_we_o   = spr_we;
  assign dma_addr_o = f_get ? f_addr : spr_addr;
  assign parity_o   = par_odd;
endmodule

// File: rtl/dma_steal_arb_chk.sv
module dma_steal_arb_chk
  import dma_steal_pkg::*;
#(
  parameter addr_t SPR_REG_ADDR = 16'h7F00
) (
  input logic  clk_i,
  input logic  rst_ni,
  input addr_t cpu_addr_i,
  input logic  cpu_rd_i,
  input logic  region_fix_i,
  input logic  rdy_o,
  input logic  dma_rd_o,
  input logic  dma_we_o,
  input logic  dup_rd_o,
  input logic  parity_o,
  input logic  fetch_vld_o,
  input logic  spr_busy
);
  logic past_ok;
  logic trig_wr;

  assign trig_wr = rdy_o && !cpu_rd_i && (cpu_addr_i == SPR_REG_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r1_par_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> parity_o != $past(parity_o));

  a_r3_no_halt_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> (cpu_rd_i || $past(trig_wr)));

  a_r4_even_halt_no_dup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rdy_o) && !parity_o) |=> !dup_rd_o);

  a_r5_dup_only_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_rd_o |-> !rdy_o);

  a_r6_fix_no_dup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region_fix_i |-> !dup_rd_o);

  a_r2_vld_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_vld_o |-> $past(dma_rd_o));

  a_r8_one_bus_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dma_rd_o && dma_we_o));

  a_r9_resume_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spr_busy) |-> !parity_o);
endmodule

bind dma_steal_arb dma_steal_arb_chk #(.SPR_REG_ADDR(SPR_REG_ADDR)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_rd_i    (cpu_rd_i),
  .region_fix_i(region_fix_i),
  .rdy_o       (rdy_o),
  .dma_rd_o    (dma_rd_o),
  .dma_we_o    (dma_we_o),
  .dup_rd_o    (dup_rd_o),
  .parity_o    (parity_o),
  .fetch_vld_o (fetch_vld_o),
  .spr_busy    (spr_busy)
);

// File: tb/dma_steal_arb_tb_top.sv
`timescale 1ns/100ps
module dma_steal_arb_tb_top;
  import dma_steal_pkg::*;

  localparam addr_t REG_A = 16'h7F00;
  localparam addr_t DAT_A = 16'h7F01;

  logic  clk = 1'b0;
  logic  rst_ni = 1'b0;
  addr_t cpu_addr = '0;
  logic  cpu_rd = 1'b1;
  data_t cpu_wdata = '0;
  logic  fetch_req = 1'b0;
  addr_t fetch_addr = '0;
  logic  region_fix = 1'b0;
  data_t dma_rdata;
  logic  rdy_o, dma_rd_o, dma_we_o, dup_rd_o, parity_o, fetch_vld_o;
  addr_t dma_addr_o;
  data_t dma_wdata_o, fetch_data_o;

  always #2 clk = ~clk;

  function automatic data_t bfun(addr_t a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign dma_rdata = bfun(dma_addr_o);

  dma_steal_arb #(.SPR_REG_ADDR(REG_A), .SPR_DATA_ADDR(DAT_A)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr), .cpu_rd_i(cpu_rd),
    .cpu_wdata_i(cpu_wdata), .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr),
    .region_fix_i(region_fix), .dma_rdata_i(dma_rdata), .rdy_o(rdy_o),
    .dma_addr_o(dma_addr_o), .dma_rd_o(dma_rd_o), .dma_we_o(dma_we_o),
    .dma_wdata_o(dma_wdata_o), .dup_rd_o(dup_rd_o), .parity_o(parity_o),
    .fetch_vld_o(fetch_vld_o), .fetch_data_o(fetch_data_o)
  );

  int checks = 0, errors = 0;
  int vld_cnt = 0, vld_bad = 0, spr_rd_cnt = 0, spr_wr_cnt = 0, spr_bad = 0;
  int op_par, st_len, st_par, st_dup, st_get, cyc = 0;
  data_t cur_page = 8'h03;
  addr_t cur_faddr = 16'hC000;

  function automatic int exp_len(int p);
    return (p == 1) ? 4 : 3;
  endfunction

  function automatic int exp_dup(int p, bit fix);
    return (p == 1 && !fix) ? 2 : 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(bit rd, addr_t a, data_t wd, bit rq);
    @(negedge clk);
    cpu_rd = rd; cpu_addr = a; cpu_wdata = wd; fetch_req = rq;
    #1;
    cyc++;
    if (fetch_vld_o) begin
      vld_cnt++;
      if (fetch_data_o != bfun(cur_faddr)) vld_bad++;
    end
    if (dma_we_o) begin
      if (dma_addr_o != DAT_A || dma_wdata_o != bfun({cur_page, 8'(spr_wr_cnt)}) || parity_o != 1'b1)
        spr_bad++;
      spr_wr_cnt++;
    end
    if (dma_rd_o && dma_addr_o[15:8] == cur_page) begin
      if (dma_addr_o[7:0] != 8'(spr_rd_cnt) || parity_o != 1'b0) spr_bad++;
      spr_rd_cnt++;
    end
    if (dma_rd_o && dma_addr_o == cur_faddr) st_get++;
  endtask

  task automatic cpu_op(bit rd, addr_t a, data_t wd, bit rq, int rq_at);
    st_len = 0; st_dup = 0; st_get = 0; st_par = -1;
    tick(rd, a, wd, rq);
    op_par = int'(parity_o);
    while (!rdy_o && st_len < 2000) begin
      if (st_len == 0) st_par = int'(parity_o);
      st_len++;
      if (dup_rd_o) st_dup++;
      tick(rd, a, wd, rq_at == st_len);
    end
  endtask

  task automatic wait_par(int p);
    cpu_op(1'b1, 16'h0100, 8'h00, 1'b0, -1);
    while (op_par != p) cpu_op(1'b1, 16'h0100, 8'h00, 1'b0, -1);
  endtask

  task automatic set_faddr(addr_t a);
    cur_faddr = a; fetch_addr = a;
  endtask

  task automatic spr_reset();
    spr_rd_cnt = 0; spr_wr_cnt = 0; spr_bad = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=expired expected=done");
    errors++; checks++;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int prev, bad, nreq, nstall, last_req, v0;
    bit rd, rq;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // reset state
    chk(parity_o == 1'b1, "R1 reset parity", parity_o, 1);
    chk(rdy_o == 1'b1 && dup_rd_o == 1'b0, "R5 reset rdy/dup", {rdy_o, dup_rd_o}, 2);
    chk(dma_rd_o == 1'b0 && dma_we_o == 1'b0 && fetch_vld_o == 1'b0, "R2 reset bus idle",
        {dma_rd_o, dma_we_o, fetch_vld_o}, 0);

    // R1 toggling
    bad = 0; prev = 1;
    for (int i = 0; i < 8; i++) begin
      cpu_op(1'b1, 16'h0100, 8'h00, 1'b0, -1);
      if (op_par == prev) bad++;
      prev = op_par;
    end
    chk(bad == 0, "R1 toggle", bad, 0);

    // R2/R5: request on even, read on next odd cycle
    wait_par(1);
    set_faddr(16'hC012);
    v0 = vld_cnt;
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b1, -1);
    chk(op_par == 0 && st_len == 0, "R7 request cycle no halt", st_len, 0);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b0, -1);
    chk(st_len == 4 && st_par == 1, "R2 odd halt length", st_len, 4);
    chk(st_dup == 2, "R5 odd halt dup count", st_dup, 2);
    chk(st_get == 1, "R2 single fetch read", st_get, 1);
    chk(vld_cnt == v0 + 1 && vld_bad == 0, "R2 fetch byte valid", vld_cnt - v0, 1);

    // R7: request on odd cycle, next even read must not halt
    wait_par(0);
    set_faddr(16'hC034);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b1, -1);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b0, -1);
    chk(op_par == 0 && st_len == 0, "R7 even cycle not eligible", st_len, 0);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b0, -1);
    chk(st_len == 4 && st_par == 1, "R7 halt on next odd", st_len, 4);

    // R3/R4: one write defers halt onto an even cycle
    wait_par(1);
    set_faddr(16'hC056);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b1, -1);
    cpu_op(1'b0, 16'h0444, 8'h11, 1'b0, -1);
    chk(st_len == 0, "R3 no halt on write", st_len, 0);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b0, -1);
    chk(st_len == 3 && st_par == 0, "R4 even halt length", st_len, 3);
    chk(st_dup == 0, "R4 even halt no dup", st_dup, 0);
    chk(st_get == 1, "R4 single fetch read", st_get, 1);

    // R3/R5: two writes defer halt onto an odd cycle
    wait_par(1);
    set_faddr(16'hC078);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b1, -1);
    cpu_op(1'b0, 16'h0444, 8'h11, 1'b0, -1);
    cpu_op(1'b0, 16'h0445, 8'h12, 1'b0, -1);
    chk(st_len == 0, "R3 write run no halt", st_len, 0);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b0, -1);
    chk(st_len == 4 && st_par == 1 && st_dup == 2, "R5 deferred odd halt", st_len * 10 + st_dup, 42);

    // R6: region fix removes duplicates
    region_fix = 1'b1;
    wait_par(1);
    set_faddr(16'hC09A);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b1, -1);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b0, -1);
    chk(st_len == 4 && st_dup == 0, "R6 fix no dup", st_len * 10 + st_dup, 40);
    region_fix = 1'b0;

    // R8/R9: sprite copy, trigger on odd cycle
    cur_page = 8'h03;
    wait_par(0);
    spr_reset();
    cpu_op(1'b0, REG_A, cur_page, 1'b0, -1);
    chk(op_par == 1, "R8 trigger parity", op_par, 1);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b0, -1);
    chk(st_len == 514, "R8 odd trigger length", st_len, 514);
    chk(parity_o == 1'b0, "R9 resume even", parity_o, 0);
    chk(spr_rd_cnt == 256 && spr_wr_cnt == 256 && spr_bad == 0, "R8 copy content",
        spr_wr_cnt * 1000 + spr_bad, 256000);

    // R8/R9: trigger on even cycle
    cur_page = 8'h05;
    wait_par(1);
    spr_reset();
    cpu_op(1'b0, REG_A, cur_page, 1'b0, -1);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b0, -1);
    chk(st_len == 513, "R8 even trigger length", st_len, 513);
    chk(parity_o == 1'b0, "R9 resume even", parity_o, 0);
    chk(spr_wr_cnt == 256 && spr_bad == 0, "R8 copy content", spr_bad, 0);

    // R10: fetch inside a copy
    cur_page = 8'h03;
    set_faddr(16'hC0AB);
    wait_par(0);
    spr_reset();
    v0 = vld_cnt;
    cpu_op(1'b0, REG_A, cur_page, 1'b0, -1);
    cpu_op(1'b1, 16'h0200, 8'h00, 1'b0, 100);
    chk(st_len == 516, "R10 copy lengthened", st_len, 516);
    chk(st_get == 1 && vld_cnt == v0 + 1 && vld_bad == 0, "R10 fetch served", st_get, 1);
    chk(spr_rd_cnt == 256 && spr_wr_cnt == 256 && spr_bad == 0, "R10 copy intact", spr_bad, 0);
    chk(parity_o == 1'b0, "R9 resume even after shared copy", parity_o, 0);

    // random mixed traffic
    void'($urandom(32'd4711));
    nreq = 0; nstall = 0; last_req = cyc;
    for (int i = 0; i < 3000; i++) begin
      region_fix = (i >= 1500);
      rd = ($urandom % 3) != 0;
      rq = ((cyc - last_req) > 450) && (($urandom % 6) == 0);
      if (rq) begin
        set_faddr(16'hC000 | addr_t'($urandom % 256));
        last_req = cyc;
        nreq++;
      end
      cpu_op(rd, addr_t'($urandom % 4096), data_t'($urandom % 256), rq, -1);
      if (st_len > 0) begin
        nstall++;
        chk(rd == 1'b1, "R3 random halt on read", rd, 1);
        chk(st_len == exp_len(st_par), "R2/R4 random stall length", st_len, exp_len(st_par));
        chk(st_dup == exp_dup(st_par, region_fix), "R5/R6 random dup count", st_dup,
            exp_dup(st_par, region_fix));
        chk(st_get == 1, "R2 random fetch read", st_get, 1);
      end
    end
    for (int i = 0; i < 10; i++) cpu_op(1'b1, 16'h0100, 8'h00, 1'b0, -1);
    chk(nstall == nreq && nreq > 0, "R7 every request served", nstall, nreq);
    chk(vld_bad == 0, "R2 fetched data", vld_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule